// File: doc/BRIEF.md
# Low-Power Clock Source Selector

This block picks the nominal 32 kHz clock that drives the always-on consumers of a chip with a main supply and a standby supply: the watchdog, the ring-indicator filter, the LED blinker and the wake-on-key logic. Three sources compete. The first is an external 32.768 kHz input. The second is a clock made by dividing the 14.318 MHz input, which is present only while main power is up. The third is an internal ring oscillator, modelled here as a clock input, which the block turns on through an enable output.

A two-bit mode field and a clock-absent bit sit in a small configuration register. Both reset only on the standby-supply reset. In the automatic mode the block falls back to the ring oscillator when main power drops. When main power returns, it moves back to the divided clock only once it has seen that clock toggle. Every change of source goes through a break-before-make gate on each source's falling edge, so the output never carries a runt pulse. Four valid flags tell each consumer whether its clock can be trusted.

Top module: `lpclk_sel_top`

## Requirements
- R1: After the standby reset the mode field is 10 and the clock-absent bit is 0. In that state the output follows the external 32 kHz input and `ring_en_o` is low.
- R2: Mode 00 selects the external input and holds `ring_en_o` low. Mode 11 is reserved and behaves as mode 10.
- R3: In mode 01, with main power up and the divided clock qualified, the output is the 14 MHz input divided by DIV_RATIO. Its high phase lasts DIV_RATIO-DIV_RATIO/2 input cycles, which at the bench ratio of 21 is a 105 ns period with 55 ns high. `ring_en_o` is high in mode 01.
- R4: In mode 01, when main power is low the output is the ring oscillator. The divided-clock gate is forced off for as long as main power is low.
- R5: After main power returns in mode 01, the output stays on the ring oscillator until two rising edges of the divided clock fall inside one window of QUAL_WIN ring-oscillator cycles (64 by default). Edges spaced further apart never qualify.
- R6: `wdt_ok_o` and `rflt_ok_o` are high only when the gated source is the divided clock, or the external input with the clock-absent bit at 0. `led_ok_o` and `wake_ok_o` are high when any source is gated through, including the ring oscillator.
- R7: With the clock-absent bit at 1 and an external mode (00, 10 or 11) selected, no source is gated. The output stays low and all four valid flags are low.
- R8: At most one source gate is on at any time. During the standby reset the output and all valid flags are low.
- R9: The mode field (`cfg_sel_i`) and the clock-absent bit (`cfg_absent_i`) are loaded on a rising edge of `clk_14m_i` while `cfg_we_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ext32_i | input | 1 | External 32.768 kHz clock |
| clk_14m_i | input | 1 | 14.318 MHz input clock, also clocks the configuration register |
| clk_ring_i | input | 1 | Ring oscillator clock (model input) |
| rst_stby_n_i | input | 1 | Active-low standby-supply power-on reset |
| main_pwr_ok_i | input | 1 | High while main power is good |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Mode field write data |
| cfg_absent_i | input | 1 | Clock-absent bit write data (1 = no external 32 kHz clock) |
| clk_lp_o | output | 1 | Selected low-power clock |
| ring_en_o | output | 1 | Ring oscillator enable |
| wdt_ok_o | output | 1 | Watchdog clock valid |
| rflt_ok_o | output | 1 | Ring filter clock valid |
| led_ok_o | output | 1 | LED blink clock valid |
| wake_ok_o | output | 1 | Wake-on-key clock valid |

## Verification
The bench tells the sources apart by the output period: 130 ns for the external input, 105 ns with a 55 ns high phase for the divided clock, and 170 ns for the ring oscillator. Each mode code is tried with main power up and down and with the clock-absent bit at either value. These runs show which source wins and whether the flags separate precise consumers from tolerant ones. The qualification step is probed by holding the 14 MHz input still after main power returns. The bench then lets single divided-clock edges through, spaced wider than the window, and finally runs the clock freely. This separates a selector that waits for two in-window edges from one that switches on main power alone or on any single edge. A stopped external clock with the absent bit set checks that the output goes quiet and every flag drops.

// File: rtl/lpclk_pkg.sv
`timescale 1ns/1ps
package lpclk_pkg;

  localparam int unsigned NUM_SRC  = 3;
  localparam int unsigned SRC_EXT  = 0;
  localparam int unsigned SRC_DIV  = 1;
  localparam int unsigned SRC_RING = 2;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  typedef enum logic [1:0] {
    MODE_EXT_FIXED = 2'b00,
    MODE_AUTO      = 2'b01,
    MODE_EXT_DFLT  = 2'b10,
    MODE_RSVD      = 2'b11
  } osc_mode_e;

  // One-hot request for the source that should drive the output.
  function automatic src_vec_t pick_req(input osc_mode_e mode,
                                        input logic main_ok,
                                        input logic div_alive);
    src_vec_t r;
    r = '0;
    if (mode == MODE_AUTO) begin
      if (main_ok && div_alive) r[SRC_DIV]  = 1'b1;
      else                      r[SRC_RING] = 1'b1;
    end else begin
      r[SRC_EXT] = 1'b1;
    end
    return r;
  endfunction

  // Precise consumers need a crystal-grade source.
  function automatic logic precise_ok(input src_vec_t on, input logic absent);
    return (on[SRC_EXT] && !absent) || on[SRC_DIV];
  endfunction

  // Tolerant consumers accept any running source.
  function automatic logic tolerant_ok(input src_vec_t on, input logic absent);
    return precise_ok(on, absent) || on[SRC_RING];
  endfunction

endpackage

// File: rtl/lpclk_divider.sv
`timescale 1ns/1ps
module lpclk_divider #(
  parameter int unsigned DIV_RATIO = 437
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic clk_div_o
);
  localparam int unsigned CNT_W = $clog2(DIV_RATIO);
  localparam int unsigned HALF  = DIV_RATIO / 2;

  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q;

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return (c == CNT_W'(DIV_RATIO - 1)) ? '0 : c + 1'b1;
  endfunction

  function automatic logic cnt_level(input logic [CNT_W-1:0] c);
    return c >= CNT_W'(HALF);
  endfunction

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_step(cnt_q);
      lvl_q <= cnt_level(cnt_step(cnt_q));
    end
  end

  assign clk_div_o = lvl_q;
endmodule

// File: rtl/lpclk_edge_qual.sv
`timescale 1ns/1ps
module lpclk_edge_qual #(
  parameter int unsigned QUAL_WIN   = 64,
  parameter int unsigned QUAL_EDGES = 2
) (
  input  logic clk_fb_i,
  input  logic rst_n_i,
  input  logic clk_tgt_i,
  input  logic tgt_rst_n_i,
  input  logic main_ok_i,
  output logic alive_o,
  output logic edge_seen_o
);
  localparam int unsigned WIN_W = $clog2(QUAL_WIN);
  localparam int unsigned HIT_W = $clog2(QUAL_EDGES + 1);

  logic             tgl_q;
  logic [2:0]       tsync_q;
  logic [1:0]       msync_q;
  logic [WIN_W-1:0] win_q;
  logic [HIT_W-1:0] hits_q;
  logic             alive_q;
  logic             win_end;

  // Toggles once per rising edge of the target clock.
  always_ff @(posedge clk_tgt_i or negedge tgt_rst_n_i) begin
    if (!tgt_rst_n_i) tgl_q <= 1'b0;
    else              tgl_q <= ~tgl_q;
  end

  assign edge_seen_o = tsync_q[2] ^ tsync_q[1];
  assign win_end     = (win_q == WIN_W'(QUAL_WIN - 1));

  always_ff @(posedge clk_fb_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      tsync_q <= '0;
      msync_q <= '0;
      win_q   <= '0;
      hits_q  <= '0;
      alive_q <= 1'b0;
    end else begin
      tsync_q <= {tsync_q[1:0], tgl_q};
      msync_q <= {msync_q[0], main_ok_i};
      if (!msync_q[1]) begin
        win_q   <= '0;
        hits_q  <= '0;
        alive_q <= 1'b0;
      end else if (!alive_q) begin
        if (edge_seen_o && (hits_q == HIT_W'(QUAL_EDGES - 1)))
          alive_q <= 1'b1;
        if (win_end) begin
          win_q  <= '0;
          hits_q <= '0;
        end else begin
          win_q <= win_q + 1'b1;
          if (edge_seen_o) hits_q <= hits_q + 1'b1;
        end
      end
    end
  end

  assign alive_o = alive_q;
endmodule

// File: rtl/lpclk_gate_cell.sv
`timescale 1ns/1ps
module lpclk_gate_cell #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic clr_n_i,
  input  logic want_i,
  output logic on_o,
  output logic clk_gated_o
);
  logic [SYNC_STAGES-1:0] sync_q;

  // Request is resynchronised on the source's own falling edge, so the
  // gate opens or closes only while that source is low.
  always_ff @(negedge clk_i or negedge clr_n_i) begin
    if (!clr_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[SYNC_STAGES-2:0], want_i};
  end

  assign on_o        = sync_q[SYNC_STAGES-1];
  assign clk_gated_o = clk_i & on_o;
endmodule

// File: rtl/lpclk_sel_top.sv
`timescale 1ns/1ps
module lpclk_sel_top
  import lpclk_pkg::*;
#(
  parameter int unsigned DIV_RATIO   = 437,
  parameter int unsigned QUAL_WIN    = 64,
  parameter int unsigned QUAL_EDGES  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_ext32_i,
  input  logic       clk_14m_i,
  input  logic       clk_ring_i,
  input  logic       rst_stby_n_i,
  input  logic       main_pwr_ok_i,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_sel_i,
  input  logic       cfg_absent_i,
  output logic       clk_lp_o,
  output logic       ring_en_o,
  output logic       wdt_ok_o,
  output logic       rflt_ok_o,
  output logic       led_ok_o,
  output logic       wake_ok_o
);
  osc_mode_e cfg_sel_q;
  logic      cfg_absent_q;

  // Named internal events, brought out for the checker.
  logic      div_clk;
  logic      div_rst_n;
  logic      qual_alive;
  logic      qual_edge;
  src_vec_t  req_vec;
  src_vec_t  gate_on;
  src_vec_t  gate_clk;
  src_vec_t  src_clk;
  src_vec_t  src_dead;

  always_ff @(posedge clk_14m_i or negedge rst_stby_n_i) begin
    if (!rst_stby_n_i) begin
      cfg_sel_q    <= MODE_EXT_DFLT;
      cfg_absent_q <= 1'b0;
    end else if (cfg_we_i) begin
      cfg_sel_q    <= osc_mode_e'(cfg_sel_i);
      cfg_absent_q <= cfg_absent_i;
    end
  end

  assign div_rst_n = rst_stby_n_i & main_pwr_ok_i;

  lpclk_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk_i     (clk_14m_i),
    .rst_n_i   (div_rst_n),
    .clk_div_o (div_clk)
  );

  lpclk_edge_qual #(.QUAL_WIN(QUAL_WIN), .QUAL_EDGES(QUAL_EDGES)) u_qual (
    .clk_fb_i    (clk_ring_i),
    .rst_n_i     (rst_stby_n_i),
    .clk_tgt_i   (div_clk),
    .tgt_rst_n_i (div_rst_n),
    .main_ok_i   (main_pwr_ok_i),
    .alive_o     (qual_alive),
    .edge_seen_o (qual_edge)
  );

  assign req_vec = pick_req(cfg_sel_q, main_pwr_ok_i, qual_alive);

  assign src_clk[SRC_EXT]   = clk_ext32_i;
  assign src_clk[SRC_DIV]   = div_clk;
  assign src_clk[SRC_RING]  = clk_ring_i;

  // A source known to be stopped cannot close its own gate; clear it.
  assign src_dead[SRC_EXT]  = cfg_absent_q;
  assign src_dead[SRC_DIV]  = ~main_pwr_ok_i;
  assign src_dead[SRC_RING] = 1'b0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    src_vec_t others;
    logic     want;
    assign others = gate_on & ~(src_vec_t'(1) << g);
    assign want   = req_vec[g] & ~(|others);
    lpclk_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk_i       (src_clk[g]),
      .clr_n_i     (rst_stby_n_i & ~src_dead[g]),
      .want_i      (want),
      .on_o        (gate_on[g]),
      .clk_gated_o (gate_clk[g])
    );
  end

  assign clk_lp_o  = |gate_clk;
  assign ring_en_o = (cfg_sel_q == MODE_AUTO) | gate_on[SRC_RING];
  assign wdt_ok_o  = precise_ok(gate_on, cfg_absent_q);
  assign rflt_ok_o = precise_ok(gate_on, cfg_absent_q);
  assign led_ok_o  = tolerant_ok(gate_on, cfg_absent_q);
  assign wake_ok_o = tolerant_ok(gate_on, cfg_absent_q);
endmodule

// File: rtl/lpclk_sva.sv
`timescale 1ns/1ps
module lpclk_sva (
  input logic       clk_i,
  input logic       rst_n_i,
  input logic       main_ok_i,
  input logic [2:0] gate_on,
  input logic       alive_i,
  input logic [1:0] mode_i,
  input logic       absent_i,
  input logic       wdt_ok_i
);
  assert_one_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0(gate_on));

  assert_div_needs_qual_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(gate_on[1]) |-> alive_i);

  assert_div_off_no_main_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !main_ok_i |-> !gate_on[1]);

  assert_ring_only_auto_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(gate_on[2]) |-> (mode_i == 2'b01));

  assert_absent_blocks_wdt_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (absent_i && !gate_on[1]) |-> !wdt_ok_i);
endmodule

bind lpclk_sel_top lpclk_sva u_sva (
  .clk_i     (clk_14m_i),
  .rst_n_i   (rst_stby_n_i),
  .main_ok_i (main_pwr_ok_i),
  .gate_on   (gate_on),
  .alive_i   (qual_alive),
  .mode_i    (cfg_sel_q),
  .absent_i  (cfg_absent_q),
  .wdt_ok_i  (wdt_ok_o)
);

// File: tb/lpclk_sel_top_tb_top.sv
`timescale 1ns/1ps
module lpclk_sel_top_tb_top;
  localparam int unsigned DIV_RATIO = 21;
  localparam real P_EXT  = 130.0;
  localparam real P_DIV  = 105.0;
  localparam real H_DIV  = 55.0;
  localparam real P_RING = 170.0;

  logic clk = 1'b0;
  logic ext_raw = 1'b0;
  logic ring_clk = 1'b0;
  logic c14_run = 1'b1;
  logic ext_run = 1'b1;
  logic rst_n = 1'b0;
  logic main_ok = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'b00;
  logic cfg_absent = 1'b0;
  logic clk14, clk_ext;
  logic clk_lp, ring_en, wdt_ok, rflt_ok, led_ok, wake_ok;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;
  always #65  ext_raw = ~ext_raw;
  always #85  ring_clk = ~ring_clk;
  assign clk14   = clk & c14_run;
  assign clk_ext = ext_raw & ext_run;

  lpclk_sel_top #(.DIV_RATIO(DIV_RATIO)) dut_i (
    .clk_ext32_i   (clk_ext),
    .clk_14m_i     (clk14),
    .clk_ring_i    (ring_clk),
    .rst_stby_n_i  (rst_n),
    .main_pwr_ok_i (main_ok),
    .cfg_we_i      (cfg_we),
    .cfg_sel_i     (cfg_sel),
    .cfg_absent_i  (cfg_absent),
    .clk_lp_o      (clk_lp),
    .ring_en_o     (ring_en),
    .wdt_ok_o      (wdt_ok),
    .rflt_ok_o     (rflt_ok),
    .led_ok_o      (led_ok),
    .wake_ok_o     (wake_ok)
  );

  real t_rise = 0.0, period = 0.0, hi_time = 0.0;
  always @(posedge clk_lp) begin
    period = $realtime - t_rise;
    t_rise = $realtime;
  end
  always @(negedge clk_lp) hi_time = $realtime - t_rise;

  function automatic real absr(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual %0.1f expected %0.1f", req, what, act, exp);
    end
  endtask

  task automatic chk_flag(input string req, input string what,
                          input logic act, input logic exp);
    chk(act === exp, req, what, real'(act), real'(exp));
  endtask

  task automatic chk_period(input string req, input real exp);
    bit running;
    running = ($realtime - t_rise) < 3.0 * exp;
    chk(running && absr(period - exp) < 1.0, req, "output period", period, exp);
  endtask

  task automatic chk_stopped(input string req);
    chk(($realtime - t_rise) > 500.0, req, "idle time since last edge",
        $realtime - t_rise, 500.0);
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic absent);
    @(negedge clk);
    cfg_sel = sel; cfg_absent = absent; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_c14(input logic run);
    @(negedge clk);
    c14_run = run;
  endtask

  task automatic set_ext(input logic run);
    @(negedge ext_raw);
    ext_run = run;
  endtask

  task automatic t_reset;
    #200;
    chk_flag("R8", "clk_lp in reset", clk_lp, 1'b0);
    chk_flag("R8", "wdt_ok in reset", wdt_ok, 1'b0);
    chk_flag("R8", "led_ok in reset", led_ok, 1'b0);
    chk_flag("R8", "ring_en in reset", ring_en, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #3000;
    chk_period("R1", P_EXT);
    chk_flag("R1", "ring_en default", ring_en, 1'b0);
    chk_flag("R6", "wdt_ok on external", wdt_ok, 1'b1);
    chk_flag("R6", "rflt_ok on external", rflt_ok, 1'b1);
    chk_flag("R6", "led_ok on external", led_ok, 1'b1);
  endtask

  task automatic t_ext_modes;
    cfg_write(2'b00, 1'b0);
    #2000;
    chk_period("R2", P_EXT);
    chk_flag("R2", "ring_en mode 00", ring_en, 1'b0);
    cfg_write(2'b11, 1'b0);
    #2000;
    chk_period("R2", P_EXT);
    chk_flag("R2", "ring_en mode 11", ring_en, 1'b0);
  endtask

  task automatic t_auto_main_up;
    cfg_write(2'b01, 1'b0);
    #4000;
    chk_period("R3", P_DIV);
    chk("R3" == "R3" && absr(hi_time - H_DIV) < 1.0, "R3", "high phase", hi_time, H_DIV);
    chk_flag("R3", "ring_en mode 01", ring_en, 1'b1);
    chk_flag("R9", "wdt_ok after write", wdt_ok, 1'b1);
    chk_flag("R6", "rflt_ok on divided", rflt_ok, 1'b1);
  endtask

  task automatic t_main_loss;
    main_ok = 1'b0;
    #3000;
    chk_period("R4", P_RING);
    chk_flag("R6", "wdt_ok on ring", wdt_ok, 1'b0);
    chk_flag("R6", "rflt_ok on ring", rflt_ok, 1'b0);
    chk_flag("R6", "led_ok on ring", led_ok, 1'b1);
    chk_flag("R6", "wake_ok on ring", wake_ok, 1'b1);
    chk_flag("R4", "ring_en on ring", ring_en, 1'b1);
  endtask

  task automatic t_qualify;
    set_c14(1'b0);
    main_ok = 1'b1;
    #5000;
    chk_period("R5", P_RING);
    chk_flag("R5", "wdt_ok with no divided edges", wdt_ok, 1'b0);
    for (int b = 0; b < 3; b++) begin
      @(negedge clk);
      c14_run = 1'b1;
      repeat (DIV_RATIO) @(negedge clk);
      c14_run = 1'b0;
      #12000;
    end
    chk_period("R5", P_RING);
    chk_flag("R5", "wdt_ok with sparse edges", wdt_ok, 1'b0);
    set_c14(1'b1);
    #4000;
    chk_period("R5", P_DIV);
    chk_flag("R5", "wdt_ok after qualification", wdt_ok, 1'b1);
  endtask

  task automatic t_absent_ext;
    set_ext(1'b0);
    cfg_write(2'b10, 1'b1);
    #3000;
    chk_stopped("R7");
    chk_flag("R7", "wdt_ok absent", wdt_ok, 1'b0);
    chk_flag("R7", "rflt_ok absent", rflt_ok, 1'b0);
    chk_flag("R7", "led_ok absent", led_ok, 1'b0);
    chk_flag("R7", "wake_ok absent", wake_ok, 1'b0);
    chk_flag("R7", "ring_en absent", ring_en, 1'b0);
  endtask

  task automatic t_absent_auto;
    cfg_write(2'b01, 1'b1);
    #3000;
    chk_period("R3", P_DIV);
    chk_flag("R6", "wdt_ok divided, ext absent", wdt_ok, 1'b1);
    main_ok = 1'b0;
    #3000;
    chk_period("R4", P_RING);
    chk_flag("R6", "wdt_ok ring, ext absent", wdt_ok, 1'b0);
    chk_flag("R6", "led_ok ring, ext absent", led_ok, 1'b1);
  endtask

  task automatic t_back_to_ext;
    main_ok = 1'b1;
    #4000;
    set_ext(1'b1);
    cfg_write(2'b10, 1'b0);
    #3000;
    chk_period("R2", P_EXT);
    chk_flag("R1", "ring_en back on external", ring_en, 1'b0);
    chk_flag("R6", "wdt_ok back on external", wdt_ok, 1'b1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000 && !done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_ext_modes();
    t_auto_main_up();
    t_main_loss();
    t_qualify();
    t_absent_ext();
    t_absent_auto();
    t_back_to_ext();
    finish_run();
  end
endmodule